// File: doc/BRIEF.md
# Serial-Loaded Seven-Segment Digit Store

This block takes display commands over a three-wire serial link (a data line, a data clock and a write strobe), all synchronised to one system clock. Each command is a 10-bit frame that carries a 4-bit character code, two annunciator bits and a 4-bit digit address. A bit counter tracks the frame. An active-low handshake output falls once exactly ten bits have arrived. A further clock edge throws the partial frame away.

A rising edge on the write strobe does one of two things. If the frame is complete, the block decodes the character to seven-segment form and latches it, with its annunciators, into the addressed digit of a ten-digit store. In every case the strobe then clears the shift logic. The whole store is presented in parallel. A shutdown input blanks the outputs but keeps the stored contents. A parameter selects the character set: hexadecimal, or a decimal set with extra symbols.

Top module: `serial_digit_store`

## Requirements
- R1: While `rst_n` is low, and after it is released, every segment and annunciator output is 0 and `accept_n_o` is 1.
- R2: Frame bits are taken on rising edges of `sclk_i`, in this order: code bits 0..3, then annunciator bits 0..1, then address bits 0..3, each field least significant bit first. Annunciator bit k of digit d drives `ann_o[2*d+k]`, where 1 is on.
- R3: `accept_n_o` is 0 exactly when ten bits are held, and 1 otherwise.
- R4: An eleventh `sclk_i` rising edge clears the frame. `accept_n_o` returns to 1, and a following write changes no digit.
- R5: A write with a complete frame and an address of 0..9 updates only that digit. Digit d occupies `seg_o[7*d +: 7]`, with bit 0 = segment a through bit 6 = segment g. The write also clears the frame.
- R6: A write with fewer than ten bits held changes no digit and clears the frame, so the next ten bits form a fresh frame.
- R7: A write with a complete frame and an address of 10..15 changes no digit and clears the frame.
- R8: With `CODE_HEX`=0, codes 0..9 show the decimal digits, and codes 10..15 show dash (g), E, H, L, P and blank, in that order.
- R9: With `CODE_HEX`=1, codes 0..15 show 0-9 and A, b, C, d, E, F.
- R10: While `shutdown_i` is 1, all segment and annunciator outputs are 0. When it drops, the stored contents reappear unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sdata_i | input | 1 | Serial frame data |
| sclk_i | input | 1 | Serial data clock; rising edge shifts |
| wr_i | input | 1 | Write strobe; rising edge commits or clears |
| shutdown_i | input | 1 | Blanks all outputs while high |
| accept_n_o | output | 1 | Low when a full frame is held |
| seg_o | output | 70 | Segments a..g of digits 0..9 |
| ann_o | output | 20 | Two annunciators per digit |

## Verification
The hardest situations to reach are the ones the handshake is there to catch. One is a write that arrives with a short frame. Another is a frame that overruns by one clock edge. The third is a full frame whose address lies beyond the last digit. In all three cases the visible result is that nothing changes. The bench therefore first fills every digit through a full sweep of addresses and codes, so that any stray write would show. It then drives each faulty sequence and compares the whole output against its model. Finally, it sends a clean frame straight afterwards, to show that the counter restarted from zero.

// File: rtl/sds_pkg.sv
package sds_pkg;
  localparam int CODE_W = 4;
  localparam int ANN_W  = 2;
  localparam int ADDR_W = 4;
  localparam int SEG_W  = 7;
  localparam int FRAME_W = CODE_W + ANN_W + ADDR_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ANN_W-1:0]  ann;
    logic [CODE_W-1:0] code;
  } frame_t;

  // segment vector: bit0 = a ... bit6 = g
  function automatic logic [SEG_W-1:0] seg_hex(input logic [CODE_W-1:0] c);
    logic [SEG_W-1:0] s;
    case (c)
      4'h0: s = 7'h3F; 4'h1: s = 7'h06; 4'h2: s = 7'h5B; 4'h3: s = 7'h4F;
      4'h4: s = 7'h66; 4'h5: s = 7'h6D; 4'h6: s = 7'h7D; 4'h7: s = 7'h07;
      4'h8: s = 7'h7F; 4'h9: s = 7'h6F; 4'hA: s = 7'h77; 4'hB: s = 7'h7C;
      4'hC: s = 7'h39; 4'hD: s = 7'h5E; 4'hE: s = 7'h79; default: s = 7'h71;
    endcase
    return s;
  endfunction

  function automatic logic [SEG_W-1:0] seg_dec(input logic [CODE_W-1:0] c);
    logic [SEG_W-1:0] s;
    case (c)
      4'hA: s = 7'h40;   // dash
      4'hB: s = 7'h79;   // E
      4'hC: s = 7'h76;   // H
      4'hD: s = 7'h38;   // L
      4'hE: s = 7'h73;   // P
      4'hF: s = 7'h00;   // blank
      default: s = seg_hex(c);
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sds_edge.sv
module sds_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/sds_shifter.sv
module sds_shifter
  import sds_pkg::*;
#(
  parameter int BITS = FRAME_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_i,
  input  logic            shift_i,
  input  logic            clear_i,
  output logic [BITS-1:0] word_o,
  output logic            full_o
);
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);

  logic [BITS-1:0]  sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    en    = clear_i | shift_i;
    if (clear_i || (shift_i && cnt_q == CNT_FULL)) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (shift_i) begin
      sr_d  = {bit_i, sr_q[BITS-1:1]};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign word_o = sr_q;
  assign full_o = (cnt_q == CNT_FULL);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  p_full_needs_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_o) |-> $past(shift_i));
  p_overrun_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !clear_i && full_o) |=> (cnt_q == '0 && !full_o));
  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/sds_seg_decode.sv
module sds_seg_decode
  import sds_pkg::*;
#(
  parameter bit CODE_HEX = 1'b0
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [SEG_W-1:0]  seg_o
);
  generate
    if (CODE_HEX) begin : g_hex
      always_comb seg_o = seg_hex(code_i);
    end else begin : g_dec
      always_comb seg_o = seg_dec(code_i);
    end
  endgenerate
endmodule

// File: rtl/serial_digit_store.sv
module serial_digit_store
  import sds_pkg::*;
#(
  parameter int NUM_DIGITS  = 10,
  parameter bit CODE_HEX    = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sdata_i,
  input  logic                      sclk_i,
  input  logic                      wr_i,
  input  logic                      shutdown_i,
  output logic                      accept_n_o,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_o,
  output logic [NUM_DIGITS*ANN_W-1:0] ann_o
);
  localparam int SEGS_ALL = NUM_DIGITS * SEG_W;
  localparam int ANNS_ALL = NUM_DIGITS * ANN_W;

  // reset release synchroniser
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // data line is delayed to match the clock synchroniser
  logic [SYNC_STAGES-1:0] dat_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) dat_q <= '0;
    else            dat_q <= {dat_q[SYNC_STAGES-2:0], sdata_i};
  end

  logic sclk_rise, wr_rise;
  sds_edge #(.STAGES(SYNC_STAGES)) u_sclk_edge (
    .clk(clk), .rst_n(rst_int_n), .d_i(sclk_i), .rise_o(sclk_rise));
  sds_edge #(.STAGES(SYNC_STAGES)) u_wr_edge (
    .clk(clk), .rst_n(rst_int_n), .d_i(wr_i), .rise_o(wr_rise));

  logic [FRAME_W-1:0] word;
  logic               full;
  frame_t             frm;
  sds_shifter #(.BITS(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .bit_i(dat_q[SYNC_STAGES-1]),
    .shift_i(sclk_rise), .clear_i(wr_rise), .word_o(word), .full_o(full));
  assign frm = frame_t'(word);

  logic [SEG_W-1:0] seg_new;
  sds_seg_decode #(.CODE_HEX(CODE_HEX)) u_dec (
    .code_i(frm.code), .seg_o(seg_new));

  logic                  commit;
  logic [NUM_DIGITS-1:0] wr_sel;
  logic [SEG_W-1:0]      seg_q [NUM_DIGITS];
  logic [ANN_W-1:0]      ann_q [NUM_DIGITS];
  logic [SEGS_ALL-1:0]   seg_flat;
  logic [ANNS_ALL-1:0]   ann_flat;

  assign commit = wr_rise & full;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
      assign wr_sel[gi] = commit && (frm.addr == ADDR_W'(gi));
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) begin
          seg_q[gi] <= '0;
          ann_q[gi] <= '0;
        end else if (wr_sel[gi]) begin
          seg_q[gi] <= seg_new;
          ann_q[gi] <= frm.ann;
        end
      end
      assign seg_flat[gi*SEG_W +: SEG_W] = seg_q[gi];
      assign ann_flat[gi*ANN_W +: ANN_W] = ann_q[gi];
    end
  endgenerate

  assign accept_n_o = ~full;
  assign seg_o      = shutdown_i ? '0 : seg_flat;
  assign ann_o      = shutdown_i ? '0 : ann_flat;

  p_one_digit_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(wr_sel));
  p_short_write_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_rise && !full) |=> ($stable(seg_flat) && $stable(ann_flat)));
  p_bad_addr_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_rise && int'(frm.addr) >= NUM_DIGITS) |=> ($stable(seg_flat) && $stable(ann_flat)));
  p_blank_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    shutdown_i |-> ($countones(seg_o) == 0 && $countones(ann_o) == 0));
endmodule

// File: tb/serial_digit_store_tb.sv
module serial_digit_store_tb;
  localparam int ND = 10;
  logic clk = 1'b0;
  logic rst_n, sdata, sclk, wr, shdn;
  logic acc_b, acc_h;
  logic [ND*7-1:0] seg_b, seg_h;
  logic [ND*2-1:0] ann_b, ann_h;
  logic [ND*7-1:0] exp_b, exp_h;
  logic [ND*2-1:0] exp_a;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_digit_store #(.NUM_DIGITS(ND), .CODE_HEX(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata), .sclk_i(sclk), .wr_i(wr),
    .shutdown_i(shdn), .accept_n_o(acc_b), .seg_o(seg_b), .ann_o(ann_b));
  serial_digit_store #(.NUM_DIGITS(ND), .CODE_HEX(1'b1)) u_dut_hex (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata), .sclk_i(sclk), .wr_i(wr),
    .shutdown_i(shdn), .accept_n_o(acc_h), .seg_o(seg_h), .ann_o(ann_h));

  function automatic logic [6:0] hexseg(input int c);
    logic [6:0] t [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                           7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
    return t[c];
  endfunction
  function automatic logic [6:0] decseg(input int c);
    logic [6:0] t [6] = '{7'h40,7'h79,7'h76,7'h38,7'h73,7'h00};
    return (c < 10) ? hexseg(c) : t[c-10];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdata = b; wait_n(4);
    sclk = 1'b1; wait_n(4);
    sclk = 1'b0; wait_n(4);
  endtask

  task automatic send_word(input int code, input int ann, input int addr);
    for (int i = 0; i < 4; i++) send_bit(code[i]);
    for (int i = 0; i < 2; i++) send_bit(ann[i]);
    for (int i = 0; i < 4; i++) send_bit(addr[i]);
  endtask

  task automatic strobe();
    wr = 1'b1; wait_n(4);
    wr = 1'b0; wait_n(4);
  endtask

  task automatic cmp_all(input string req);
    @(negedge clk);
    chk(seg_b == exp_b, req, 128'(seg_b), 128'(exp_b));
    chk(seg_h == exp_h, req, 128'(seg_h), 128'(exp_h));
    chk(ann_b == exp_a && ann_h == exp_a, req, 128'(ann_b), 128'(exp_a));
  endtask

  task automatic chk_acc(input logic e, input string req);
    @(negedge clk);
    chk(acc_b == e && acc_h == e, req, 128'(acc_b), 128'(e));
  endtask

  initial begin
    wait_n(200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sdata = 1'b0; sclk = 1'b0; wr = 1'b0; shdn = 1'b0;
    exp_b = '0; exp_h = '0; exp_a = '0;
    wait_n(3);
    cmp_all("R1 in reset"); chk_acc(1'b1, "R1");
    rst_n = 1'b1; wait_n(4);
    cmp_all("R1 after release"); chk_acc(1'b1, "R1");

    // R2 R3 R5 R8 R9: sweep every address and code
    for (int a = 0; a < ND; a++) begin
      for (int c = 0; c < 16; c++) begin
        int an;
        an = (c + a) & 3;
        send_word(c, an, a);
        chk_acc(1'b0, "R3 full frame");
        strobe();
        exp_b[a*7 +: 7] = decseg(c);
        exp_h[a*7 +: 7] = hexseg(c);
        exp_a[a*2 +: 2] = 2'(an);
        cmp_all("R2 R5 R8 R9 write");
        chk_acc(1'b1, "R5 cleared");
      end
    end

    // R3: partial frames keep handshake high
    for (int i = 0; i < 9; i++) send_bit(1'b1);
    chk_acc(1'b1, "R3 nine bits");
    // R6: short write changes nothing and restarts counting
    strobe();
    cmp_all("R6 short write"); chk_acc(1'b1, "R6");
    send_word(4, 3, 2);
    chk_acc(1'b0, "R6 fresh frame");
    strobe();
    exp_b[2*7 +: 7] = decseg(4); exp_h[2*7 +: 7] = hexseg(4); exp_a[2*2 +: 2] = 2'd3;
    cmp_all("R6 fresh frame write");

    // R4: eleventh edge drops frame
    send_word(8, 1, 5);
    send_bit(1'b0);
    chk_acc(1'b1, "R4 overrun");
    strobe();
    cmp_all("R4 overrun write");
    send_word(1, 2, 5);
    chk_acc(1'b0, "R4 recovered");
    strobe();
    exp_b[5*7 +: 7] = decseg(1); exp_h[5*7 +: 7] = hexseg(1); exp_a[5*2 +: 2] = 2'd2;
    cmp_all("R4 recovered write");

    // R7: out-of-range addresses
    for (int a = ND; a < 16; a++) begin
      send_word(8, 3, a);
      strobe();
      cmp_all("R7 bad address"); chk_acc(1'b1, "R7 cleared");
    end

    // R10: shutdown blanks, contents kept
    shdn = 1'b1; wait_n(2);
    @(negedge clk);
    chk(seg_b == '0 && seg_h == '0, "R10 seg blank", 128'(seg_b), 128'(0));
    chk(ann_b == '0 && ann_h == '0, "R10 ann blank", 128'(ann_b), 128'(0));
    shdn = 1'b0; wait_n(2);
    cmp_all("R10 restored");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule